// File: doc/BRIEF.md
# Banked Register Context Switch Controller

This controller performs the fast software-interrupt context switch of a processor that keeps eight register banks in a small on-chip RAM. When it receives a start request and a target bank number, it saves the current flags word and program counter into that bank's save slots. It then fetches the bank's vector word as the new program counter and writes the bank number into the bank field of the flags word. State is saved into the bank's own RAM area and never onto a stack. The active bank is defined only by flags bits 14:12.

The bank RAM is 256 bytes with a 16-bit data port and a one-cycle registered read. It is byte-addressed, and every access is word-aligned. Each bank is 32 bytes long and starts at `bank*32`. Inside a bank, the vector word is at +2, the saved flags at +4 and the saved program counter at +6. The twelve general registers sit at +8 through +30, in the index order DS0, SS, PS, DS1, IY, IX, BP, SP, BW, DW, CW, AW. The block also converts a register index into that index's RAM address in the active bank for the datapath. The flags word and the program counter are held in this block. The datapath can load them while the block is idle.

The sequencer has seven states. IDLE goes to WR_FLAGS on an accepted start. WR_FLAGS always goes to WR_PC. WR_PC always goes to RD_VEC. RD_VEC always goes to CAP_VEC. CAP_VEC always goes to SETTLE. SETTLE counts padding cycles and goes to FINISH after the last one. FINISH always returns to IDLE, and on that edge it commits the new program counter and flags. The cycle in which start is accepted is cycle 0. The states then occupy cycles 1, 2, 3 and 4, then cycles 5 to 14, then cycle 15.

Top module: `bank_ctx_switch`

## Requirements
- R1: After reset, `flags` reads 0x8000, `pc` reads 0, and `busy` and `done` are low.
- R2: In cycle 1 after an accepted start, the block writes the flags value from cycle 0 to byte address `bank*32+4`.
- R3: In cycle 2, the block writes the program counter from cycle 0 to byte address `bank*32+6`.
- R4: In cycle 3, the block issues a read of byte address `bank*32+2` with `ram_we` low. In every other cycle `ram_we` and `ram_re` are low, except for the writes of R2 and R3.
- R5: `busy` is high in cycles 1 to 15. `done` is high only in cycle 15, and for exactly one cycle.
- R6: From cycle 16 on, `pc` equals the word read from the vector slot, and flags bits 14:12 equal the target bank. All other flags bits are unchanged.
- R7: Only `operand[2:0]` selects the bank. Bits 7:3 have no effect.
- R8: `flags[15]` always reads 1, whatever value is loaded.
- R9: `flags_ld` and `pc_ld` take effect on the next edge only when the block is idle and `start` is low. Otherwise they are ignored, including in the cycle where a start is accepted.
- R10: A `start` raised while `busy` is high is ignored. No second switch occurs.
- R11: `reg_addr` equals `flags[14:12]*32 + 8 + 2*reg_idx` for `reg_idx` values 0 to 11, which select DS0, SS, PS, DS1, IY, IX, BP, SP, BW, DW, CW and AW in that order. After a switch, the new bank applies from cycle 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Switch request, accepted only when idle |
| operand | input | 8 | Request operand; the low 3 bits give the target bank |
| busy | output | 1 | High while a switch is in progress |
| done | output | 1 | One-cycle pulse in the final cycle of a switch |
| flags_ld | input | 1 | Load `flags_d` into the flags word (idle only) |
| flags_d | input | 16 | Flags load value |
| pc_ld | input | 1 | Load `pc_d` into the program counter (idle only) |
| pc_d | input | 16 | Program counter load value |
| flags | output | 16 | Current flags word; bits 14:12 are the active bank |
| pc | output | 16 | Current program counter |
| reg_idx | input | 4 | General register index, 0 to 11 |
| reg_addr | output | 8 | RAM byte address of `reg_idx` in the active bank |
| ram_addr | output | 8 | Bank RAM byte address |
| ram_we | output | 1 | Bank RAM write strobe |
| ram_re | output | 1 | Bank RAM read strobe; data returns on the next cycle |
| ram_wdata | output | 16 | Bank RAM write data |
| ram_rdata | input | 16 | Bank RAM read data, registered |

## Verification
The assertions assume that the bank RAM returns read data exactly one cycle after `ram_re`. They also assume that `reg_idx` stays within 0 to 11, because larger values would address the next bank. The bench's RAM model has that one-cycle latency, and random register indices are drawn only from that range. Loads and repeated starts are driven while a switch is in flight, both to exercise R9 and R10 and to show that the state the assertions expect to stay stable does not move.

// File: rtl/bank_ctx_pkg.sv
package bank_ctx_pkg;

    // Sequencer states, in the order they are visited
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_FLAGS,
        ST_WR_PC,
        ST_RD_VEC,
        ST_CAP_VEC,
        ST_SETTLE,
        ST_FINISH
    } ctx_state_e;

    // Flags word layout: the bank field and the always-one bit
    localparam int FLAGS_W       = 16;
    localparam int BANK_FIELD_LO = 12;
    localparam int BANK_FIELD_HI = 14;
    localparam int FIXED_ONE_BIT = 15;

    // Byte offsets of the save slots inside one bank
    localparam int SLOT_VEC_OFF   = 2;
    localparam int SLOT_FLAGS_OFF = 4;
    localparam int SLOT_PC_OFF    = 6;
    localparam int REG_BASE_OFF   = 8;

    // Number of sequencer cycles that are not padding
    localparam int FIXED_STEPS = 5;

endpackage

// File: rtl/bank_slot_addr.sv
module bank_slot_addr #(
    parameter int BANK_W = 3,
    parameter int OFF_W  = 5
) (
    input  logic [BANK_W-1:0]       bank,
    input  logic [OFF_W-1:0]        offset,
    output logic [BANK_W+OFF_W-1:0] addr
);
    // Banks are a power-of-two size, so the base is a plain concatenation
    assign addr = {bank, offset};
endmodule

// File: rtl/bank_ctx_fsm.sv
module bank_ctx_fsm
    import bank_ctx_pkg::*;
#(
    parameter int SWITCH_CYCLES = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic idle,
    output logic accept,
    output logic busy,
    output logic done,
    output logic wr_flags,
    output logic wr_pc,
    output logic rd_vec,
    output logic cap_vec,
    output logic commit
);
    localparam int PAD   = SWITCH_CYCLES - FIXED_STEPS;
    localparam int CNT_W = (PAD > 1) ? $clog2(PAD) : 1;
    localparam logic [CNT_W-1:0] PAD_LAST = CNT_W'(PAD - 1);

    ctx_state_e       state_q, state_d;
    logic [CNT_W-1:0] pad_q;

    // State register and padding counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pad_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SETTLE) pad_q <= pad_q + 1'b1;
            else                      pad_q <= '0;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_WR_FLAGS;
            ST_WR_FLAGS: state_d = ST_WR_PC;
            ST_WR_PC:    state_d = ST_RD_VEC;
            ST_RD_VEC:   state_d = ST_CAP_VEC;
            ST_CAP_VEC:  state_d = ST_SETTLE;
            ST_SETTLE:   if (pad_q == PAD_LAST) state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Outputs per state
    always_comb begin
        idle     = 1'b0;
        accept   = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        wr_flags = 1'b0;
        wr_pc    = 1'b0;
        rd_vec   = 1'b0;
        cap_vec  = 1'b0;
        commit   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idle   = 1'b1;
                busy   = 1'b0;
                accept = start;
            end
            ST_WR_FLAGS: wr_flags = 1'b1;
            ST_WR_PC:    wr_pc    = 1'b1;
            ST_RD_VEC:   rd_vec   = 1'b1;
            ST_CAP_VEC:  cap_vec  = 1'b1;
            ST_SETTLE:   ;
            ST_FINISH: begin
                done   = 1'b1;
                commit = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/bank_ctx_state.sv
module bank_ctx_state
    import bank_ctx_pkg::*;
#(
    parameter int                BANK_W    = 3,
    parameter int                OPERAND_W = 8,
    parameter int                WORD_W    = 16,
    parameter logic [WORD_W-1:0] RESET_PC  = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 idle,
    input  logic                 start,
    input  logic                 accept,
    input  logic [OPERAND_W-1:0] operand,
    input  logic                 flags_ld,
    input  logic [FLAGS_W-1:0]   flags_d,
    input  logic                 pc_ld,
    input  logic [WORD_W-1:0]    pc_d,
    input  logic                 cap_vec,
    input  logic [WORD_W-1:0]    vec_word,
    input  logic                 commit,
    output logic [FLAGS_W-1:0]   flags,
    output logic [WORD_W-1:0]    pc,
    output logic [BANK_W-1:0]    tgt_bank
);
    localparam logic [FLAGS_W-1:0] ONE_MASK = FLAGS_W'(1) << FIXED_ONE_BIT;

    logic [FLAGS_W-1:0] flags_q;
    logic [WORD_W-1:0]  pc_q;
    logic [WORD_W-1:0]  vec_q;
    logic               ld_ok;

    assign ld_ok = idle && !start;

    // Target bank, latched when a switch is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tgt_bank <= '0;
        else if (accept) tgt_bank <= BANK_W'(operand);
    end

    // Holding register for the fetched vector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       vec_q <= '0;
        else if (cap_vec) vec_q <= vec_word;
    end

    // Flags word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= ONE_MASK;
        end else if (commit) begin
            flags_q <= ONE_MASK;
            flags_q[BANK_FIELD_HI:BANK_FIELD_LO] <= tgt_bank;
            flags_q[BANK_FIELD_LO-1:0]           <= flags_q[BANK_FIELD_LO-1:0];
        end else if (ld_ok && flags_ld) begin
            flags_q <= flags_d | ONE_MASK;
        end
    end

    // Program counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pc_q <= RESET_PC;
        else if (commit)           pc_q <= vec_q;
        else if (ld_ok && pc_ld)   pc_q <= pc_d;
    end

    assign flags = flags_q;
    assign pc    = pc_q;
endmodule

// File: rtl/bank_ctx_switch.sv
module bank_ctx_switch
    import bank_ctx_pkg::*;
#(
    parameter int        NUM_BANKS     = 8,
    parameter int        BANK_BYTES    = 32,
    parameter int        WORD_W        = 16,
    parameter int        OPERAND_W     = 8,
    parameter int        REG_IDX_W     = 4,
    parameter int        SWITCH_CYCLES = 15,
    parameter logic [15:0] RESET_PC    = 16'h0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [OPERAND_W-1:0] operand,
    output logic                 busy,
    output logic                 done,
    input  logic                 flags_ld,
    input  logic [15:0]          flags_d,
    input  logic                 pc_ld,
    input  logic [WORD_W-1:0]    pc_d,
    output logic [15:0]          flags,
    output logic [WORD_W-1:0]    pc,
    input  logic [REG_IDX_W-1:0] reg_idx,
    output logic [7:0]           reg_addr,
    output logic [7:0]           ram_addr,
    output logic                 ram_we,
    output logic                 ram_re,
    output logic [WORD_W-1:0]    ram_wdata,
    input  logic [WORD_W-1:0]    ram_rdata
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int OFF_W  = $clog2(BANK_BYTES);
    localparam int RAM_AW = BANK_W + OFF_W;
    localparam int N_LOOKUP = 2;   // 0: switch slots, 1: register mapping

    logic              idle, accept, wr_flags, wr_pc, rd_vec, cap_vec, commit;
    logic [BANK_W-1:0] tgt_bank;
    logic [OFF_W-1:0]  slot_off;
    logic [OFF_W-1:0]  reg_off;

    logic [BANK_W-1:0] lk_bank [N_LOOKUP];
    logic [OFF_W-1:0]  lk_off  [N_LOOKUP];
    logic [RAM_AW-1:0] lk_addr [N_LOOKUP];

    bank_ctx_fsm #(
        .SWITCH_CYCLES (SWITCH_CYCLES)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .idle     (idle),
        .accept   (accept),
        .busy     (busy),
        .done     (done),
        .wr_flags (wr_flags),
        .wr_pc    (wr_pc),
        .rd_vec   (rd_vec),
        .cap_vec  (cap_vec),
        .commit   (commit)
    );

    bank_ctx_state #(
        .BANK_W    (BANK_W),
        .OPERAND_W (OPERAND_W),
        .WORD_W    (WORD_W),
        .RESET_PC  (WORD_W'(RESET_PC))
    ) i_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle     (idle),
        .start    (start),
        .accept   (accept),
        .operand  (operand),
        .flags_ld (flags_ld),
        .flags_d  (flags_d),
        .pc_ld    (pc_ld),
        .pc_d     (pc_d),
        .cap_vec  (cap_vec),
        .vec_word (ram_rdata),
        .commit   (commit),
        .flags    (flags),
        .pc       (pc),
        .tgt_bank (tgt_bank)
    );

    // Slot offset for the current step of a switch
    always_comb begin
        slot_off = OFF_W'(SLOT_VEC_OFF);
        if (wr_flags)   slot_off = OFF_W'(SLOT_FLAGS_OFF);
        else if (wr_pc) slot_off = OFF_W'(SLOT_PC_OFF);
    end

    assign reg_off = OFF_W'(REG_BASE_OFF) + OFF_W'({reg_idx, 1'b0});

    assign lk_bank[0] = tgt_bank;
    assign lk_off[0]  = slot_off;
    assign lk_bank[1] = flags[BANK_FIELD_HI:BANK_FIELD_LO];
    assign lk_off[1]  = reg_off;

    for (genvar g = 0; g < N_LOOKUP; g++) begin : g_lookup
        bank_slot_addr #(
            .BANK_W (BANK_W),
            .OFF_W  (OFF_W)
        ) i_addr (
            .bank   (lk_bank[g]),
            .offset (lk_off[g]),
            .addr   (lk_addr[g])
        );
    end

    assign ram_addr  = lk_addr[0];
    assign reg_addr  = lk_addr[1];
    assign ram_we    = wr_flags || wr_pc;
    assign ram_re    = rd_vec;
    assign ram_wdata = wr_flags ? flags : (wr_pc ? pc : '0);
endmodule

// File: rtl/bank_ctx_switch_chk.sv
module bank_ctx_switch_chk #(
    parameter int SWITCH_CYCLES = 15
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [2:0]  op_bank,
    input logic        busy,
    input logic        done,
    input logic [15:0] flags,
    input logic [15:0] pc,
    input logic [7:0]  ram_addr,
    input logic        ram_we,
    input logic        ram_re,
    input logic [15:0] ram_wdata
);
    localparam int LAT_W = $clog2(SWITCH_CYCLES + 2);

    logic [LAT_W-1:0] lat_cnt;
    logic [2:0]       bank_lat;

    // Cycle count since the accepted start, and the bank it asked for
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_cnt  <= '0;
            bank_lat <= '0;
        end else if (start && !busy) begin
            lat_cnt  <= LAT_W'(1);
            bank_lat <= op_bank;
        end else if (busy) begin
            lat_cnt  <= lat_cnt + 1'b1;
        end
    end

    AST_SAVE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (ram_we && ram_addr[4:0] == 5'd4 && ram_addr[7:5] == $past(op_bank) && ram_wdata == $past(flags))); // R2
    AST_SAVE_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr[4:0] == 5'd4) |=> (ram_we && ram_addr[4:0] == 5'd6 && ram_wdata == pc)); // R3
    AST_READ_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr[4:0] == 5'd6) |=> (ram_re && !ram_we && ram_addr[4:0] == 5'd2)); // R4
    AST_RAM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && lat_cnt == LAT_W'(SWITCH_CYCLES))); // R5
    AST_COMMIT_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && flags[14:12] == bank_lat)); // R6
    AST_FLAGS_TOP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        flags[15]); // R8
    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(flags) && $stable(pc))); // R9
endmodule

bind bank_ctx_switch bank_ctx_switch_chk #(
    .SWITCH_CYCLES (SWITCH_CYCLES)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_bank   (operand[2:0]),
    .busy      (busy),
    .done      (done),
    .flags     (flags),
    .pc        (pc),
    .ram_addr  (ram_addr),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .ram_wdata (ram_wdata)
);

// File: tb/test_bank_ctx_switch.sv
`timescale 1ns/1ps
module test_bank_ctx_switch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  operand = '0;
    logic        busy, done;
    logic        flags_ld = 1'b0;
    logic [15:0] flags_d = '0;
    logic        pc_ld = 1'b0;
    logic [15:0] pc_d = '0;
    logic [15:0] flags, pc;
    logic [3:0]  reg_idx = '0;
    logic [7:0]  reg_addr;
    logic [7:0]  ram_addr;
    logic        ram_we, ram_re;
    logic [15:0] ram_wdata;
    logic [15:0] ram_rdata = '0;

    // Bench-side RAM preload port
    logic        tb_wr = 1'b0;
    logic [6:0]  tb_widx = '0;
    logic [15:0] tb_wdata = '0;
    logic [15:0] mem [0:127];

    int checks = 0;
    int errors = 0;
    logic [15:0] f_exp = 16'h8000;
    logic [15:0] p_exp = 16'h0000;

    always #2.5 clk = ~clk;

    bank_ctx_switch i_bank_ctx_switch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .operand   (operand),
        .busy      (busy),
        .done      (done),
        .flags_ld  (flags_ld),
        .flags_d   (flags_d),
        .pc_ld     (pc_ld),
        .pc_d      (pc_d),
        .flags     (flags),
        .pc        (pc),
        .reg_idx   (reg_idx),
        .reg_addr  (reg_addr),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .ram_re    (ram_re),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata)
    );

    // RAM model: word array, registered read
    always @(posedge clk) begin
        if (tb_wr)  mem[tb_widx] <= tb_wdata;
        if (ram_we) mem[ram_addr[7:1]] <= ram_wdata;
        if (ram_re) ram_rdata <= mem[ram_addr[7:1]];
    end

    function automatic logic [7:0] slot_addr(input logic [2:0] b, input int off);
        return 8'(int'(b) * 32 + off);
    endfunction

    function automatic logic [7:0] reg_map(input logic [2:0] b, input int idx);
        return 8'(int'(b) * 32 + 8 + 2 * idx);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [6:0] idx, input logic [15:0] val);
        tb_widx  = idx;
        tb_wdata = val;
        tb_wr    = 1'b1;
        @(negedge clk);
        tb_wr    = 1'b0;
    endtask

    task automatic load_state(input logic [15:0] f, input logic [15:0] p);
        flags_ld = 1'b1; flags_d = f;
        pc_ld    = 1'b1; pc_d    = p;
        @(negedge clk);
        flags_ld = 1'b0; pc_ld = 1'b0;
        f_exp = f | 16'h8000;
        p_exp = p;
        check("R8 flags after load", flags, f_exp);
        check("R9 pc after idle load", pc, p_exp);
    endtask

    // One full switch; optional load in the start cycle and disturbance mid-flight
    task automatic run_switch(input logic [7:0] op, input logic [15:0] vec,
                              input bit load_at_start, input bit disturb);
        logic [2:0] b;
        b = op[2:0];
        preload({b, 4'd1}, vec);
        operand = op;
        start   = 1'b1;
        if (load_at_start) begin
            flags_ld = 1'b1; flags_d = 16'h0FFF ^ f_exp;
            pc_ld    = 1'b1; pc_d    = ~p_exp;
        end
        for (int k = 1; k <= 15; k++) begin
            @(negedge clk);
            if (k == 1) begin
                start = 1'b0; flags_ld = 1'b0; pc_ld = 1'b0;
                operand = $urandom;
            end
            if (k == 8) begin
                start = 1'b0; flags_ld = 1'b0; pc_ld = 1'b0;
            end
            check("R5 busy in switch", busy, 1'b1);
            check("R5 done timing", done, (k == 15));
            if (k == 1) begin
                check("R2 flags write strobe", {ram_we, ram_re}, 2'b10);
                check("R2 flags slot address", ram_addr, slot_addr(b, 4));
                check("R2 flags write data", ram_wdata, f_exp);
            end else if (k == 2) begin
                check("R3 pc write strobe", {ram_we, ram_re}, 2'b10);
                check("R3 pc slot address", ram_addr, slot_addr(b, 6));
                check("R3 pc write data", ram_wdata, p_exp);
            end else if (k == 3) begin
                check("R4 vector read strobe", {ram_we, ram_re}, 2'b01);
                check("R4 vector slot address", ram_addr, slot_addr(b, 2));
            end else begin
                check("R4 idle RAM port", {ram_we, ram_re}, 2'b00);
            end
            if (k == 7 && disturb) begin
                start    = 1'b1; operand = $urandom;
                flags_ld = 1'b1; flags_d = $urandom;
                pc_ld    = 1'b1; pc_d    = $urandom;
            end
        end
        @(negedge clk);
        check("R2 saved flags in RAM", mem[{b, 4'd2}], f_exp);
        check("R3 saved pc in RAM", mem[{b, 4'd3}], p_exp);
        f_exp = {1'b1, b, f_exp[11:0]};
        p_exp = vec;
        check("R6 flags after switch", flags, f_exp);
        check("R6 pc after switch", pc, p_exp);
        check("R10 no second switch", {busy, done}, 2'b00);
        @(negedge clk);
        check("R10 still idle", busy, 1'b0);
        check("R9 state unchanged", {flags, pc}, {f_exp, p_exp});
    endtask

    task automatic check_regmap(input int idx);
        reg_idx = 4'(idx);
        #1;
        check("R11 register address", reg_addr, reg_map(f_exp[14:12], idx));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0B2C));
        for (int i = 0; i < 128; i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 flags at reset", flags, 16'h8000);
        check("R1 pc at reset", pc, 16'h0000);
        check("R1 busy/done at reset", {busy, done}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 register map bank 0", reg_addr, reg_map(3'd0, 0));

        // R8: bit 15 forced even when loaded with zero
        load_state(16'h0000, 16'h1234);
        load_state(16'h0A5F, 16'hBEEF);

        // Directed: bank 7 with upper operand bits set (R7), then bank 0
        run_switch(8'hFF, 16'hC0DE, 1'b0, 1'b0);
        check_regmap(11);
        check_regmap(0);
        run_switch(8'hF8, 16'h4000, 1'b0, 1'b0);
        check_regmap(11);
        // R9: load in the accepted-start cycle is ignored
        run_switch(8'h05, 16'h0777, 1'b1, 1'b0);
        // R10/R9: disturbance during a switch
        run_switch(8'h32, 16'h2222, 1'b0, 1'b1);

        // Constrained random mix
        for (int n = 0; n < 24; n++) begin
            if (($urandom % 3) == 0) load_state(16'($urandom), 16'($urandom));
            run_switch(8'($urandom), 16'($urandom), ($urandom % 4) == 0, ($urandom % 2) == 0);
            check_regmap(int'($urandom % 12));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule